// File: doc/BRIEF.md
# Centralized Shared-Bus Arbiter with Selectable Scheme

This block decides which one of `NDEV` modules owns a single shared bus. A two-bit scheme input picks how the decision is made. In the first scheme each module has its own request and grant pair. In the second, the requests are merged onto one shared request line, and the grant ripples through the modules in chain order. In the third, the arbiter broadcasts a device number that steps through the modules once per clock.

A module keeps its request bit high for as long as it wants to use the bus. The arbiter raises that module's grant bit and drives bus-busy while the module holds the bus. When the owner drops its request, the grant and busy clear on the next edge, and a new arbitration can begin one cycle after that. The block has no data path. All pins are plain control levels, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_arbiter`

## Requirements
- R1: At most one bit of `gnt` is high in any cycle, and `bus_busy` is high exactly when one grant bit is high.
- R2: With `scheme` = 0 (or the unused code 3) and the bus idle, the requesting module with the lowest index gets its grant on the next clock edge.
- R3: With `scheme` = 1, `chain_req` is high when at least one request is high and the bus is not busy. It stays low while the bus is busy, even when other modules are requesting.
- R4: With `scheme` = 1 and the bus idle, the grant passes along the chain from index 0 upward. The first requesting module captures it on the next clock edge.
- R5: With `scheme` = 2, a request seen while the bus is idle starts a poll: `poll_active` goes high and `dev_num` is loaded on the next edge. While `poll_active` is high, `dev_num` advances by one per clock and wraps from `NDEV-1` to 0. If module `dev_num` is requesting, it is granted on the next edge.
- R6: The poll start index is 0 when `poll_from_next` = 0. When `poll_from_next` = 1, it is the index after the most recent owner, modulo `NDEV`. After reset the most recent owner counts as `NDEV-1`.
- R7: The owner keeps its grant for as long as its request stays high. A request from any other module, including a lower index, does not take the bus away.
- R8: When the owner drops its request, `gnt` and `bus_busy` go low on the next edge. No new grant appears before the edge after that.
- R9: With no request high, no grant is issued and `bus_busy` stays low. If all requests drop during a poll, `poll_active` falls on the next edge and no grant is made.
- R10: During reset, `gnt` is zero, `bus_busy`, `chain_req` and `poll_active` are low, and `dev_num` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scheme | input | 2 | Selects the scheme: 0 = independent request, 1 = chain, 2 = counter poll, 3 = treated as 0 |
| poll_from_next | input | 1 | Selects the poll start: 0 = start at index 0, 1 = start at the index after the last owner |
| req | input | NDEV | Request level for each module, held high while the module uses the bus |
| gnt | output | NDEV | One-hot ownership grant |
| bus_busy | output | 1 | High while the bus is owned |
| chain_req | output | 1 | Shared request line used in chain mode |
| poll_active | output | 1 | High while a device-number poll is in progress |
| dev_num | output | $clog2(NDEV) | Device number currently being polled |

## Verification
An error in the ownership register shows up on `gnt` and `bus_busy` at the next sampling point. It appears as a second grant bit, a grant that outlives its request by more than one cycle, or a lower index taking over a held bus. An error in the poll counter appears on `dev_num` on the edge after the poll starts. It also shifts the grant cycle by at least one clock, so the bench counts the edges from the first request to the grant. Errors in the chain or in the start-index selection appear as the wrong module winning the first grant of an arbitration.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ARB_INDEP = 2'd0,
    ARB_CHAIN = 2'd1,
    ARB_POLL  = 2'd2,
    ARB_RSVD  = 2'd3
  } arb_scheme_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_OWNED = 2'd2
  } arb_state_e;
endpackage

// File: rtl/arb_fixed_pri.sv
module arb_fixed_pri #(
  parameter int NDEV = 4
) (
  input  logic [NDEV-1:0] req,
  output logic [NDEV-1:0] pick
);
  logic [NDEV:0] lower;
  assign lower[0] = 1'b0;
  for (genvar i = 0; i < NDEV; i++) begin : g_pri
    assign pick[i]    = req[i] & ~lower[i];
    assign lower[i+1] = lower[i] | req[i];
  end
endmodule

// File: rtl/arb_chain.sv
module arb_chain #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_in,
  input  logic [NDEV-1:0] req,
  output logic [NDEV-1:0] take
);
  logic [NDEV-1:0] pass;
  assign pass[0] = grant_in;
  for (genvar i = 0; i < NDEV; i++) begin : g_cell
    assign take[i] = pass[i] & req[i];
    if (i < NDEV - 1) begin : g_fwd
      assign pass[i+1] = pass[i] & ~req[i];
    end
  end

  AST_CHAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_in && (|req)) |-> ($onehot(take) && ((take & req) == take))); // R4
endmodule

// File: rtl/arb_poll_ctr.sv
module arb_poll_ctr #(
  parameter int NDEV = 4,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [IW-1:0] start_idx,
  input  logic          advance,
  output logic [IW-1:0] cnt
);
  localparam logic [IW-1:0] LAST = IW'(NDEV - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= start_idx;
    else if (advance) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  AST_POLL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1))); // R5
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int NDEV = 4,
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      scheme,
  input  logic            poll_from_next,
  input  logic [NDEV-1:0] req,
  output logic [NDEV-1:0] gnt,
  output logic            bus_busy,
  output logic            chain_req,
  output logic            poll_active,
  output logic [IW-1:0]   dev_num
);
  localparam logic [IW-1:0] LAST = IW'(NDEV - 1);

  arb_scheme_e     sch;
  arb_state_e      state_q;
  logic [NDEV-1:0] gnt_q;
  logic [IW-1:0]   last_q;
  logic            any_req;
  logic [NDEV-1:0] pick;
  logic [NDEV-1:0] take;
  logic            chain_in;
  logic [IW-1:0]   start_idx;
  logic [IW-1:0]   cnt;
  logic            poll_load;
  logic            poll_adv;
  logic            poll_hit;

  function automatic logic [IW-1:0] to_index(input logic [NDEV-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NDEV; i++) if (v[i]) r = IW'(i);
    return r;
  endfunction

  assign sch       = arb_scheme_e'(scheme);
  assign any_req   = |req;
  assign bus_busy  = |gnt_q;
  assign gnt       = gnt_q;
  assign chain_req = (sch == ARB_CHAIN) && any_req && !bus_busy;
  assign chain_in  = (state_q == ST_IDLE) && chain_req;
  assign start_idx = poll_from_next ? ((last_q == LAST) ? '0 : last_q + 1'b1) : '0;
  assign poll_load = (state_q == ST_IDLE) && any_req && (sch == ARB_POLL);
  assign poll_hit  = (state_q == ST_POLL) && req[cnt];
  assign poll_adv  = (state_q == ST_POLL) && any_req && !req[cnt];
  assign poll_active = (state_q == ST_POLL);
  assign dev_num   = cnt;

  arb_fixed_pri #(.NDEV(NDEV)) u_pri (
    .req  (req),
    .pick (pick)
  );

  arb_chain #(.NDEV(NDEV)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant_in (chain_in),
    .req      (req),
    .take     (take)
  );

  arb_poll_ctr #(.NDEV(NDEV)) u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (poll_load),
    .start_idx (start_idx),
    .advance   (poll_adv),
    .cnt       (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      last_q  <= LAST;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (any_req) begin
            if (sch == ARB_POLL) begin
              state_q <= ST_POLL;
            end else if (sch == ARB_CHAIN) begin
              gnt_q   <= take;
              last_q  <= to_index(take);
              state_q <= ST_OWNED;
            end else begin
              gnt_q   <= pick;
              last_q  <= to_index(pick);
              state_q <= ST_OWNED;
            end
          end
        end
        ST_POLL: begin
          if (!any_req) begin
            state_q <= ST_IDLE;
          end else if (poll_hit) begin
            gnt_q   <= {{(NDEV-1){1'b0}}, 1'b1} << cnt;
            last_q  <= cnt;
            state_q <= ST_OWNED;
          end
        end
        ST_OWNED: begin
          if (!(|(gnt_q & req))) begin
            gnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: begin
          gnt_q   <= '0;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt & req)) |=> (gnt == $past(gnt))); // R7
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt) && !(|(gnt & req))) |=> (gnt == '0)); // R8
  AST_POLL_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && req[dev_num]) |=> (gnt == ({{(NDEV-1){1'b0}}, 1'b1} << $past(dev_num)))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && !bus_busy) |=> !bus_busy); // R9
endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;
  localparam int NDEV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      scheme = 2'd0;
  logic            poll_from_next = 1'b0;
  logic [NDEV-1:0] req = '0;
  logic [NDEV-1:0] gnt;
  logic            bus_busy;
  logic            chain_req;
  logic            poll_active;
  logic [1:0]      dev_num;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bus_arbiter #(.NDEV(NDEV)) u0 (
    .clk(clk), .rst_n(rst_n), .scheme(scheme), .poll_from_next(poll_from_next),
    .req(req), .gnt(gnt), .bus_busy(bus_busy), .chain_req(chain_req),
    .poll_active(poll_active), .dev_num(dev_num)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic release_all();
    req = '0;
    tick();
    tick();
  endtask

  // Ticks until a grant shows up, returning the number of edges taken.
  task automatic wait_grant(output int edges);
    edges = 0;
    for (int k = 0; k < 12; k++) begin
      tick();
      edges++;
      if (gnt != '0) break;
    end
  endtask

  task automatic t_reset();
    chk("R10 gnt", gnt, 0);
    chk("R10 busy", bus_busy, 0);
    chk("R10 chain_req", chain_req, 0);
    chk("R10 poll_active", poll_active, 0);
    chk("R10 dev_num", dev_num, 0);
  endtask

  task automatic t_indep();
    scheme = 2'd0;
    req = 4'b1010;
    tick();
    chk("R2 lowest wins", gnt, 4'b0010);
    chk("R1 busy", bus_busy, 1);
    req = 4'b1011;
    tick(); tick();
    chk("R7 no preempt", gnt, 4'b0010);
    req = 4'b1001;
    tick();
    chk("R8 grant clears", gnt, 0);
    chk("R8 busy clears", bus_busy, 0);
    tick();
    chk("R2 next arbitration", gnt, 4'b0001);
    release_all();
    scheme = 2'd3;
    req = 4'b0100;
    tick();
    chk("R2 code3 as indep", gnt, 4'b0100);
    release_all();
  endtask

  task automatic t_idle();
    scheme = 2'd0;
    req = '0;
    tick(); tick(); tick();
    chk("R9 no grant", gnt, 0);
    chk("R9 not busy", bus_busy, 0);
  endtask

  task automatic t_chain();
    scheme = 2'd1;
    req = 4'b1100;
    #1;
    chk("R3 shared req raised", chain_req, 1);
    tick();
    chk("R4 nearest captures", gnt, 4'b0100);
    chk("R3 shared req low while busy", chain_req, 0);
    req = 4'b1000;
    tick();
    chk("R8 chain release", gnt, 0);
    chk("R3 shared req after release", chain_req, 1);
    tick();
    chk("R4 next in chain", gnt, 4'b1000);
    release_all();
  endtask

  task automatic t_poll();
    int e;
    scheme = 2'd2;
    poll_from_next = 1'b0;
    req = 4'b1000;
    tick();
    chk("R5 poll starts", poll_active, 1);
    chk("R5 dev_num loaded", dev_num, 0);
    chk("R5 no early grant", gnt, 0);
    tick();
    chk("R5 dev_num steps", dev_num, 1);
    wait_grant(e);
    chk("R5 grant edges", e, 3);
    chk("R5 polled module granted", gnt, 4'b1000);
    release_all();
    req = 4'b0011;
    wait_grant(e);
    chk("R6 from zero edges", e, 2);
    chk("R6 from zero winner", gnt, 4'b0001);
    release_all();
    poll_from_next = 1'b1;
    req = 4'b0011;
    wait_grant(e);
    chk("R6 from next edges", e, 2);
    chk("R6 from next winner", gnt, 4'b0010);
    release_all();
    req = 4'b0001;
    wait_grant(e);
    chk("R6 wrap edges", e, 4);
    chk("R6 wrap winner", gnt, 4'b0001);
    release_all();
    poll_from_next = 1'b0;
    req = 4'b1000;
    tick();
    req = '0;
    tick();
    chk("R9 poll abandoned", poll_active, 0);
    chk("R9 poll no grant", gnt, 0);
    release_all();
  endtask

  initial begin
    #1;
    t_reset();
    #50;
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_indep();
    t_idle();
    t_chain();
    t_poll();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule